// File: doc/BRIEF.md
# Preamplifier Gain Control Register Bank

This block is the register file of a digitally controlled microphone preamplifier. A host engine, which is not part of this block, reaches it through a 3-bit register select with one-cycle read and write strobes and a byte data path. The block holds a fixed identification byte, a 6-bit gain setting, a small general-purpose output register and a control/status byte. Every gain value that is written is checked. A value in the forbidden band is refused and raises a sticky error flag. A legal value either reaches the applied-gain output at once or waits for a zero-crossing strobe, depending on the selected gain mode. A busy flag reports that a change is waiting.

The general-purpose output pins have a second use. While reset is held they are inputs, and the block samples a device address from the low pins. Once reset is released they turn into outputs and follow the stored register bits.

Top module: `gainctl_regbank`

## Requirements
- R1: After reset the stored gain, the applied gain, the mode (code 00), ERR, BSY and the output register bits are all zero.
- R2: Register select 000 reads 0x84, made of chip code 100001 in bits 7:2 and revision 00 in bits 1:0. Writes to it change nothing.
- R3: A gain write (select 001, value in bits 5:0) is legal for 0 and for 8 to 63. A value from 1 to 7 leaves the stored and applied gain unchanged and sets ERR.
- R4: ERR stays set through further illegal writes and clears on the next legal gain write.
- R5: In mode 00, a legal gain write shows on the applied-gain output after the clock edge that takes the write, and BSY stays 0.
- R6: In mode 01, a legal write that differs from the applied gain sets BSY and leaves the applied gain unchanged. The first zero-crossing strobe while BSY is set copies the stored gain to the output and clears BSY at the same edge. A strobe while BSY is clear has no effect, and a write equal to the applied gain leaves BSY clear.
- R7: A legal write while a change is pending replaces the pending value. An illegal write leaves the pending value and BSY as they were.
- R8: The mode field takes only codes 00 and 01, and a write of 10 or 11 leaves it unchanged. Writing mode 00 while a change is pending applies that change at the same edge.
- R9: While reset is held, the pin output enables are 0 and the device address is sampled from input pins 2:0. After reset all enables are 1 and each pin drives its register bit (1 high, 0 low).
- R10: Select 010 stores bits 3:0 and reads back the stored bits, with bits 7:4 zero, never the pin levels.
- R11: Select 011 reads BSY in bit 7, ERR in bit 4 and the mode in bits 1:0, with all other bits 0. Selects 100 to 111 read 0. Read data is loaded on the edge that takes a read strobe and holds between reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; pins are sampled while low |
| reg_sel | input | 3 | Register select |
| wr_stb | input | 1 | Write strobe |
| rd_stb | input | 1 | Read strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| zc_stb | input | 1 | Zero-crossing strobe |
| gain_applied | output | 6 | Gain currently applied to the switched resistors |
| pin_in | input | 4 | Levels seen on the output pins |
| pin_out | output | 4 | Values driven on the output pins |
| pin_oe | output | 4 | Output enables of the pins |
| dev_addr | output | 3 | Device address sampled during reset |

## Verification
The bench aims at the boundary of the forbidden band (7 against 8, and 0 against 1). A design that checks only for zero would let small gains through, and one with an off-by-one bound would refuse gain 8. It checks that ERR is sticky and that an illegal write between a pending write and its strobe changes nothing. A design that drops or overwrites the pending value there would apply the wrong gain at the next crossing. It also covers a strobe that arrives with nothing pending, a reserved mode code, and a switch back to immediate mode while a change waits. Designs that lose the pending change or lock into a reserved mode give a wrong applied gain or a wrong mode field. Finally, it drives pin levels that differ from the register bits, so that a read path wired to the pins shows up.

// File: rtl/gainctl_pkg.sv
package gainctl_pkg;

   localparam int unsigned DATA_W = 8;
   localparam int unsigned SEL_W  = 3;

   localparam logic [SEL_W-1:0] SEL_IDENT = 3'b000;
   localparam logic [SEL_W-1:0] SEL_GAIN  = 3'b001;
   localparam logic [SEL_W-1:0] SEL_GPO   = 3'b010;
   localparam logic [SEL_W-1:0] SEL_CTRL  = 3'b011;

   typedef enum logic [1:0] {
      GM_IMMEDIATE = 2'b00,
      GM_ZEROCROSS = 2'b01
   } gain_mode_e;

   localparam int unsigned CTRL_BSY_BIT = 7;
   localparam int unsigned CTRL_ERR_BIT = 4;

endpackage

// File: rtl/gainctl_gain_unit.sv
module gainctl_gain_unit
   import gainctl_pkg::*;
#(
   parameter int unsigned GAIN_W   = 6,
   parameter int unsigned GAIN_MIN = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_gain,
   input  logic              wr_ctrl,
   input  logic [DATA_W-1:0] wdata,
   input  logic              zc,
   output logic [GAIN_W-1:0] gain_reg,
   output logic [GAIN_W-1:0] gain_applied,
   output gain_mode_e        mode,
   output logic              busy,
   output logic              err
);

   localparam logic [GAIN_W-1:0] MIN_V = GAIN_W'(GAIN_MIN);

   logic [GAIN_W-1:0] wval;
   logic              legal;
   logic              mode_ok;
   logic              apply_pending;

   logic [GAIN_W-1:0] gain_reg_d, applied_d;
   gain_mode_e        mode_d;
   logic              busy_d, err_d;

   assign wval    = wdata[GAIN_W-1:0];
   assign legal   = (wval == '0) || (wval >= MIN_V);
   assign mode_ok = (wdata[1:0] == GM_IMMEDIATE) || (wdata[1:0] == GM_ZEROCROSS);

   // a waiting change is taken by a crossing unless a legal gain write arrives at the same edge
   assign apply_pending = busy && zc && !(wr_gain && legal);

   always_comb begin
      gain_reg_d = gain_reg;
      applied_d  = gain_applied;
      mode_d     = mode;
      busy_d     = busy;
      err_d      = err;
      if (apply_pending) begin
         applied_d = gain_reg;
         busy_d    = 1'b0;
      end
      if (wr_gain) begin
         if (legal) begin
            gain_reg_d = wval;
            err_d      = 1'b0;
            if (mode == GM_IMMEDIATE) begin
               applied_d = wval;
               busy_d    = 1'b0;
            end else begin
               busy_d    = (wval != gain_applied);
            end
         end else begin
            err_d = 1'b1;
         end
      end
      if (wr_ctrl && mode_ok) begin
         mode_d = gain_mode_e'(wdata[1:0]);
         if (mode_d == GM_IMMEDIATE && busy) begin
            applied_d = gain_reg;
            busy_d    = 1'b0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gain_reg     <= '0;
         gain_applied <= '0;
         mode         <= GM_IMMEDIATE;
         busy         <= 1'b0;
         err          <= 1'b0;
      end else begin
         gain_reg     <= gain_reg_d;
         gain_applied <= applied_d;
         mode         <= mode_d;
         busy         <= busy_d;
         err          <= err_d;
      end
   end

endmodule

// File: rtl/gainctl_gpo_port.sv
module gainctl_gpo_port #(
   parameter int unsigned GPO_W     = 4,
   parameter int unsigned DEVADDR_W = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_gpo,
   input  logic [GPO_W-1:0]     wbits,
   input  logic [GPO_W-1:0]     pin_in,
   output logic [GPO_W-1:0]     pin_out,
   output logic [GPO_W-1:0]     pin_oe,
   output logic [GPO_W-1:0]     gpo_reg,
   output logic [DEVADDR_W-1:0] dev_addr
);

   logic drive_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gpo_reg <= '0;
         drive_q <= 1'b0;
      end else begin
         drive_q <= 1'b1;
         if (wr_gpo) gpo_reg <= wbits;
      end
   end

   // address strap is sampled on every edge while reset is held
   always_ff @(posedge clk) begin
      if (!rst_n) dev_addr <= pin_in[DEVADDR_W-1:0];
   end

   for (genvar i = 0; i < GPO_W; i++) begin : g_pin
      assign pin_out[i] = gpo_reg[i];
      assign pin_oe[i]  = drive_q;
   end

endmodule

// File: rtl/gainctl_regbank.sv
module gainctl_regbank
   import gainctl_pkg::*;
#(
   parameter int unsigned GAIN_W    = 6,
   parameter int unsigned GAIN_MIN  = 8,
   parameter int unsigned GPO_W     = 4,
   parameter int unsigned DEVADDR_W = 3,
   parameter logic [5:0]  CHIP_CODE = 6'b100001,
   parameter logic [1:0]  REV_CODE  = 2'b00
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [2:0]           reg_sel,
   input  logic                 wr_stb,
   input  logic                 rd_stb,
   input  logic [7:0]           wr_data,
   output logic [7:0]           rd_data,
   input  logic                 zc_stb,
   output logic [GAIN_W-1:0]    gain_applied,
   input  logic [GPO_W-1:0]     pin_in,
   output logic [GPO_W-1:0]     pin_out,
   output logic [GPO_W-1:0]     pin_oe,
   output logic [DEVADDR_W-1:0] dev_addr
);

   localparam logic [DATA_W-1:0] IDENT_BYTE = {CHIP_CODE, REV_CODE};

   if (GAIN_W > DATA_W || GAIN_W < 2) begin : g_bad_gain_w
      $error("GAIN_W must fit the data byte");
   end
   if (GAIN_MIN >= (1 << GAIN_W)) begin : g_bad_gain_min
      $error("GAIN_MIN out of gain range");
   end
   if (GPO_W > DATA_W || DEVADDR_W > GPO_W) begin : g_bad_gpo
      $error("GPO widths inconsistent");
   end

   logic [GAIN_W-1:0] gain_reg;
   gain_mode_e        mode;
   logic              busy, err;
   logic [GPO_W-1:0]  gpo_reg;
   logic              wr_gain, wr_ctrl, wr_gpo;
   logic [DATA_W-1:0] rd_mux;

   assign wr_gain = wr_stb && (reg_sel == SEL_GAIN);
   assign wr_ctrl = wr_stb && (reg_sel == SEL_CTRL);
   assign wr_gpo  = wr_stb && (reg_sel == SEL_GPO);

   gainctl_gain_unit #(.GAIN_W(GAIN_W), .GAIN_MIN(GAIN_MIN)) u_gain (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_gain      (wr_gain),
      .wr_ctrl      (wr_ctrl),
      .wdata        (wr_data),
      .zc           (zc_stb),
      .gain_reg     (gain_reg),
      .gain_applied (gain_applied),
      .mode         (mode),
      .busy         (busy),
      .err          (err)
   );

   gainctl_gpo_port #(.GPO_W(GPO_W), .DEVADDR_W(DEVADDR_W)) u_gpo (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_gpo   (wr_gpo),
      .wbits    (wr_data[GPO_W-1:0]),
      .pin_in   (pin_in),
      .pin_out  (pin_out),
      .pin_oe   (pin_oe),
      .gpo_reg  (gpo_reg),
      .dev_addr (dev_addr)
   );

   always_comb begin
      rd_mux = '0;
      case (reg_sel)
         SEL_IDENT: rd_mux = IDENT_BYTE;
         SEL_GAIN:  rd_mux[GAIN_W-1:0] = gain_reg;
         SEL_GPO:   rd_mux[GPO_W-1:0]  = gpo_reg;
         SEL_CTRL: begin
            rd_mux[CTRL_BSY_BIT] = busy;
            rd_mux[CTRL_ERR_BIT] = err;
            rd_mux[1:0]          = mode;
         end
         default:   rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rd_data <= '0;
      else if (rd_stb) rd_data <= rd_mux;
   end

endmodule

// File: rtl/gainctl_regbank_chk.sv
module gainctl_regbank_chk #(
   parameter int unsigned GAIN_W   = 6,
   parameter int unsigned GAIN_MIN = 8,
   parameter int unsigned GPO_W    = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic [2:0]        reg_sel,
   input logic              wr_stb,
   input logic              rd_stb,
   input logic [7:0]        wr_data,
   input logic [7:0]        rd_data,
   input logic              zc_stb,
   input logic [GAIN_W-1:0] gain_reg,
   input logic [GAIN_W-1:0] gain_applied,
   input logic [1:0]        mode,
   input logic              busy,
   input logic              err,
   input logic [GPO_W-1:0]  pin_oe
);

   localparam logic [GAIN_W-1:0] MIN_V = GAIN_W'(GAIN_MIN);

   logic [GAIN_W-1:0] wv;
   logic gain_wr, wv_legal;
   assign wv       = wr_data[GAIN_W-1:0];
   assign gain_wr  = wr_stb && reg_sel == 3'b001;
   assign wv_legal = (wv == '0) || (wv >= MIN_V);

   AST_IDENT_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
      rd_stb && reg_sel == 3'b000 |=> rd_data == 8'h84); // R2

   AST_APPLIED_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      gain_applied == '0 || gain_applied >= MIN_V); // R3

   AST_ILLEGAL_SETS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      gain_wr && !wv_legal |=> err && $stable(gain_reg)); // R3

   AST_ILLEGAL_KEEPS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      gain_wr && !wv_legal && !(busy && zc_stb) |=> $stable(busy) && $stable(gain_applied)); // R7

   AST_LEGAL_CLEARS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      gain_wr && wv_legal |=> !err); // R4

   AST_IMMEDIATE_APPLY: assert property (@(posedge clk) disable iff (!rst_n)
      gain_wr && wv_legal && mode == 2'b00 |=> gain_applied == $past(wv) && !busy); // R5

   AST_ZC_APPLY: assert property (@(posedge clk) disable iff (!rst_n)
      busy && zc_stb && !(gain_wr && wv_legal) |=> !busy && gain_applied == $past(gain_reg)); // R6

   AST_IDLE_MATCHES: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> gain_applied == gain_reg); // R6

   AST_MODE_NOT_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
      mode[1] == 1'b0); // R8

   always @(negedge clk) begin
      if (!rst_n) begin
         AST_PINS_UNDRIVEN_IN_RESET: assert (pin_oe == '0); // R9
      end
   end

endmodule

bind gainctl_regbank gainctl_regbank_chk #(
   .GAIN_W(GAIN_W), .GAIN_MIN(GAIN_MIN), .GPO_W(GPO_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .reg_sel      (reg_sel),
   .wr_stb       (wr_stb),
   .rd_stb       (rd_stb),
   .wr_data      (wr_data),
   .rd_data      (rd_data),
   .zc_stb       (zc_stb),
   .gain_reg     (gain_reg),
   .gain_applied (gain_applied),
   .mode         (mode),
   .busy         (busy),
   .err          (err),
   .pin_oe       (pin_oe)
);

// File: tb/tb_gainctl_regbank.sv
module tb_gainctl_regbank;

   localparam time CLK_PERIOD = 10ns;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] reg_sel = '0;
   logic       wr_stb = 1'b0;
   logic       rd_stb = 1'b0;
   logic [7:0] wr_data = '0;
   logic [7:0] rd_data;
   logic       zc_stb = 1'b0;
   logic [5:0] gain_applied;
   logic [3:0] pin_in = 4'b0101;
   logic [3:0] pin_out, pin_oe;
   logic [2:0] dev_addr;

   int n_checks = 0;
   int n_fails  = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   gainctl_regbank dut (
      .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_stb(wr_stb), .rd_stb(rd_stb),
      .wr_data(wr_data), .rd_data(rd_data), .zc_stb(zc_stb), .gain_applied(gain_applied),
      .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .dev_addr(dev_addr)
   );

   task automatic check(input string req, input string what, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fails++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] s, input logic [7:0] d);
      @(negedge clk);
      reg_sel = s; wr_data = d; wr_stb = 1'b1;
      @(negedge clk);
      wr_stb = 1'b0;
   endtask

   task automatic rd(input logic [2:0] s, output logic [7:0] d);
      @(negedge clk);
      reg_sel = s; rd_stb = 1'b1;
      @(negedge clk);
      rd_stb = 1'b0;
      d = rd_data;
   endtask

   task automatic zc_pulse();
      @(negedge clk);
      zc_stb = 1'b1;
      @(negedge clk);
      zc_stb = 1'b0;
   endtask

   task automatic t_reset();
      logic [7:0] d;
      repeat (3) @(negedge clk);
      check("R9", "oe in reset", int'(pin_oe), 0);
      rst_n = 1'b1;
      pin_in = 4'b1010;
      repeat (2) @(negedge clk);
      check("R9", "dev addr", int'(dev_addr), 3'b101);
      check("R9", "oe after reset", int'(pin_oe), 4'hF);
      check("R1", "applied gain", int'(gain_applied), 0);
      rd(3'b011, d); check("R1", "ctrl", int'(d), 0);
      rd(3'b001, d); check("R1", "gain reg", int'(d), 0);
      rd(3'b010, d); check("R1", "gpo reg", int'(d), 0);
      check("R1", "pins", int'(pin_out), 0);
   endtask

   task automatic t_ident();
      logic [7:0] d;
      rd(3'b000, d); check("R2", "ident", int'(d), 8'h84);
      wr(3'b000, 8'hFF);
      rd(3'b000, d); check("R2", "ident after write", int'(d), 8'h84);
      rd(3'b101, d); check("R11", "unmapped", int'(d), 0);
      rd(3'b111, d); check("R11", "unmapped hi", int'(d), 0);
      rd(3'b000, d);
      @(negedge clk); reg_sel = 3'b101;
      @(negedge clk); check("R11", "rdata holds", int'(rd_data), 8'h84);
   endtask

   task automatic t_immediate();
      logic [7:0] d;
      wr(3'b001, 8'd8);  check("R5", "apply 8", int'(gain_applied), 8);
      wr(3'b001, 8'd63); check("R5", "apply 63", int'(gain_applied), 63);
      wr(3'b001, 8'd0);  check("R5", "apply 0", int'(gain_applied), 0);
      rd(3'b011, d);     check("R5", "bsy clear", int'(d[7]), 0);
   endtask

   task automatic t_illegal();
      logic [7:0] d;
      wr(3'b001, 8'd20);
      wr(3'b001, 8'd7);
      check("R3", "applied after 7", int'(gain_applied), 20);
      rd(3'b001, d);  check("R3", "reg after 7", int'(d), 20);
      rd(3'b011, d);  check("R3", "err set", int'(d), 8'h10);
      wr(3'b001, 8'd1);
      check("R3", "applied after 1", int'(gain_applied), 20);
      rd(3'b011, d);  check("R4", "err sticky", int'(d[4]), 1);
      wr(3'b001, 8'd0);
      check("R3", "zero legal", int'(gain_applied), 0);
      rd(3'b011, d);  check("R4", "err cleared", int'(d), 0);
      wr(3'b001, 8'd5);
      wr(3'b001, 8'd8);
      check("R3", "eight legal", int'(gain_applied), 8);
      rd(3'b011, d);  check("R4", "err cleared by 8", int'(d[4]), 0);
   endtask

   task automatic t_zerocross();
      logic [7:0] d;
      wr(3'b011, 8'h01);
      zc_pulse();
      check("R6", "zc idle no effect", int'(gain_applied), 8);
      wr(3'b001, 8'd30);
      check("R6", "held", int'(gain_applied), 8);
      rd(3'b011, d); check("R6", "bsy set", int'(d), 8'h81);
      zc_pulse();
      check("R6", "applied at zc", int'(gain_applied), 30);
      rd(3'b011, d); check("R6", "bsy clear", int'(d), 8'h01);
      wr(3'b001, 8'd30);
      rd(3'b011, d); check("R6", "equal write no bsy", int'(d[7]), 0);
   endtask

   task automatic t_replace();
      logic [7:0] d;
      wr(3'b001, 8'd40);
      wr(3'b001, 8'd41);
      wr(3'b001, 8'd3);
      rd(3'b011, d); check("R7", "bsy and err", int'(d), 8'h91);
      check("R7", "still held", int'(gain_applied), 30);
      zc_pulse();
      check("R7", "replaced value applied", int'(gain_applied), 41);
   endtask

   task automatic t_mode();
      logic [7:0] d;
      wr(3'b011, 8'h02);
      rd(3'b011, d); check("R8", "reserved ignored", int'(d[1:0]), 1);
      wr(3'b011, 8'h03);
      rd(3'b011, d); check("R8", "reserved 11 ignored", int'(d[1:0]), 1);
      wr(3'b001, 8'd50);
      check("R8", "pending", int'(gain_applied), 41);
      wr(3'b011, 8'h00);
      check("R8", "switch applies", int'(gain_applied), 50);
      rd(3'b011, d); check("R8", "ctrl after switch", int'(d), 0);
   endtask

   task automatic t_gpo();
      logic [7:0] d;
      pin_in = 4'b0101;
      wr(3'b010, 8'h0A);
      check("R9", "pins driven", int'(pin_out), 4'hA);
      rd(3'b010, d); check("R10", "gpo read", int'(d), 8'h0A);
      wr(3'b010, 8'hF3);
      rd(3'b010, d); check("R10", "upper bits zero", int'(d), 8'h03);
      check("R9", "pins follow", int'(pin_out), 4'h3);
   endtask

   initial begin
      t_reset();
      t_ident();
      t_immediate();
      t_illegal();
      t_zerocross();
      t_replace();
      t_mode();
      t_gpo();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            n_checks++; n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
   end

endmodule